// File: doc/BRIEF.md
# Two-Segment Relocation and Bounds Checker

This block translates the relative addresses issued by a single running process into physical addresses. The process owns two segments: a code segment and a data segment. Each segment has its own base and limit register. The top bit of the incoming virtual address picks the segment. The remaining bits form an offset that is compared against that segment's limit. An offset inside the limit produces the physical address base plus offset. An offset at or beyond the limit produces a protection fault instead, and no address reaches memory.

Privileged software loads the four registers through a small write port while it sets up the process, before handing control to it. After that, every instruction fetch and every operand access passes through the block. The translation is registered. The request side and the response side each carry a valid/ready handshake, so a stalled memory system holds the result in place. Because the two register pairs are independent, two processes can point their code bases at one shared copy of the code while keeping separate data segments.

Top module: `relo_unit`

## Requirements
- R1: After synchronous reset, out_valid is 0 and all four registers are 0. Every access therefore faults, because any offset is at least a zero limit.
- R2: Virtual address bit VA_W-1 selects the segment: 0 selects the data pair and 1 selects the code pair. out_code reports the selected segment as 1 for code and 0 for data.
- R3: For a permitted access, out_paddr equals the selected base plus the zero-extended offset (vaddr bits VA_W-2..0), taken modulo 2^PA_W. The sum wraps and raises no fault.
- R4: An access whose offset is greater than or equal to the selected limit gives out_fault=1 and out_paddr=0. An offset of limit-1 is still permitted.
- R5: When cfg_we is 1, cfg_wdata is written into the register chosen by cfg_sel. Bit 1 of cfg_sel picks the segment (1 is code, 0 is data). Bit 0 picks the register (1 is limit, 0 is base). The other three registers are left unchanged.
- R6: A register write in the same cycle as an accepted request does not affect that request. It affects every request accepted afterwards.
- R7: A request accepted at a clock edge (req_valid and req_ready both 1) appears on the outputs with out_valid=1 right after that edge.
- R8: While out_valid=1 and out_ready=0, req_ready is 0 and out_paddr, out_fault and out_code hold steady. The next request is accepted in the cycle in which the stalled result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: bit 1 chooses the segment (1 code), bit 0 chooses the register (1 limit) |
| cfg_wdata | input | PA_W | Register write value |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Relative virtual address: segment bit on top, offset below it |
| out_valid | output | 1 | Translation result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_paddr | output | PA_W | Physical address, 0 when faulted |
| out_fault | output | 1 | Protection fault; no memory request is made |
| out_code | output | 1 | Segment used: 1 code, 0 data |

## Verification
Two situations are hardest to reach from the ports. The first is a register write that lands in the same cycle a request is accepted. The bench drives both on one falling edge, then checks that the result still uses the old base, and that the next access uses the new one. The second is a downstream stall with a second request waiting. The bench holds out_ready low with a new request already presented, checks over several cycles that the first result does not move and that the second request is refused, then releases the stall and checks that the second result follows one cycle later. Limit boundaries (limit-1 and limit) and a base that wraps the address space are driven directly on both segments.

// File: rtl/relo_pkg.sv
package relo_pkg;
  typedef enum logic {
    SEG_DATA = 1'b0,
    SEG_CODE = 1'b1
  } seg_e;

  localparam int unsigned N_SEG = 2;

  // cfg_sel bit positions
  localparam int unsigned SEL_SEG_BIT = 1;
  localparam int unsigned SEL_LIM_BIT = 0;
endpackage

// File: rtl/relo_seg_regs.sv
module relo_seg_regs
  import relo_pkg::*;
#(
  parameter int unsigned PA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [1:0]                  cfg_sel,
  input  logic [PA_W-1:0]             cfg_wdata,
  output logic [N_SEG-1:0][PA_W-1:0]  base_o,
  output logic [N_SEG-1:0][PA_W-1:0]  lim_o
);

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    logic hit;
    assign hit = cfg_we && (cfg_sel[SEL_SEG_BIT] == 1'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[g] <= '0;
        lim_o[g]  <= '0;
      end else if (hit) begin
        if (cfg_sel[SEL_LIM_BIT]) lim_o[g] <= cfg_wdata;
        else                      base_o[g] <= cfg_wdata;
      end
    end

    // R5: a limit write lands in the addressed segment only
    p_lim_write_r5: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_sel[SEL_SEG_BIT] == 1'(g) && cfg_sel[SEL_LIM_BIT])
      |=> (lim_o[g] == $past(cfg_wdata)));

    // R5: writes aimed at the other segment leave this pair unchanged
    p_other_seg_r5: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_sel[SEL_SEG_BIT] != 1'(g))
      |=> ($stable(lim_o[g]) && $stable(base_o[g])));
  end

endmodule

// File: rtl/relo_xlate.sv
module relo_xlate
  import relo_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = VA_W
) (
  input  logic [VA_W-1:0]             vaddr,
  input  logic [N_SEG-1:0][PA_W-1:0]  base_i,
  input  logic [N_SEG-1:0][PA_W-1:0]  lim_i,
  output logic                        seg_code,
  output logic [PA_W-1:0]             paddr,
  output logic                        fault
);
  localparam int unsigned OFF_W = VA_W - 1;

  seg_e            seg;
  logic [PA_W-1:0] off_ext;
  logic [PA_W-1:0] base_sel;
  logic [PA_W-1:0] lim_sel;

  always_comb begin
    seg      = seg_e'(vaddr[VA_W-1]);
    off_ext  = PA_W'(vaddr[OFF_W-1:0]);
    base_sel = base_i[seg];
    lim_sel  = lim_i[seg];
    fault    = (off_ext >= lim_sel);
    paddr    = fault ? '0 : (base_sel + off_ext);
    seg_code = (seg == SEG_CODE);
  end

endmodule

// File: rtl/relo_out_stage.sv
module relo_out_stage #(
  parameter int unsigned PA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_fault,
  input  logic            in_code,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_fault,
  output logic            out_code
);

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_paddr <= '0;
      out_fault <= 1'b0;
      out_code  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_paddr <= in_paddr;
        out_fault <= in_fault;
        out_code  <= in_code;
      end
    end
  end

  // R7: an accepted request is presented right after the accepting edge
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R8: a stalled result holds its contents
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready)
    |=> (out_valid && $stable(out_paddr) && $stable(out_fault) && $stable(out_code)));

  // R4: a faulted result never carries an address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault) |-> (out_paddr == '0));

endmodule

// File: rtl/relo_unit.sv
module relo_unit
  import relo_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = VA_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_fault,
  output logic            out_code
);

  logic [N_SEG-1:0][PA_W-1:0] base_q;
  logic [N_SEG-1:0][PA_W-1:0] lim_q;
  logic                       x_code;
  logic [PA_W-1:0]            x_paddr;
  logic                       x_fault;

  relo_seg_regs #(.PA_W(PA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_o    (base_q),
    .lim_o     (lim_q)
  );

  relo_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
    .vaddr    (req_vaddr),
    .base_i   (base_q),
    .lim_i    (lim_q),
    .seg_code (x_code),
    .paddr    (x_paddr),
    .fault    (x_fault)
  );

  relo_out_stage #(.PA_W(PA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_paddr  (x_paddr),
    .in_fault  (x_fault),
    .in_code   (x_code),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_paddr (out_paddr),
    .out_fault (out_fault),
    .out_code  (out_code)
  );

endmodule

// File: tb/tb_relo_unit.sv
module tb_relo_unit;
  localparam int VA_W = 16;
  localparam int PA_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [PA_W-1:0] out_paddr;
  logic out_fault;
  logic out_code;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  relo_unit #(.VA_W(VA_W), .PA_W(PA_W)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // sel: {code, limit}
  task automatic wr(logic code, logic lim, logic [PA_W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {code, lim}; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(string tag, logic [VA_W-1:0] va,
                        logic [PA_W-1:0] ep, logic ef, logic ec);
    @(negedge clk);
    out_ready = 1'b1;
    chk({tag, " idle before accept R7"}, out_valid, 0);
    chk({tag, " ready R8"}, req_ready, 1);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid R7"}, out_valid, 1);
    chk({tag, " paddr"}, out_paddr, ep);
    chk({tag, " fault"}, out_fault, ef);
    chk({tag, " seg R2"}, out_code, ec);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    access("R1 zero limit faults data", 16'h0000, 16'h0000, 1, 0);
    access("R1 zero limit faults code", 16'h8000, 16'h0000, 1, 1);
  endtask

  task automatic t_program();
    wr(0, 0, 16'h4000); wr(0, 1, 16'h0100);
    wr(1, 0, 16'h9000); wr(1, 1, 16'h0200);
    access("R2 R3 data", 16'h0010, 16'h4010, 0, 0);
    access("R2 R3 code", 16'h8010, 16'h9010, 0, 1);
  endtask

  task automatic t_bounds();
    access("R4 data limit-1", 16'h00FF, 16'h40FF, 0, 0);
    access("R4 data at limit", 16'h0100, 16'h0000, 1, 0);
    access("R4 code limit-1", 16'h81FF, 16'h91FF, 0, 1);
    access("R4 code at limit", 16'h8200, 16'h0000, 1, 1);
    access("R4 code max offset", 16'hFFFF, 16'h0000, 1, 1);
  endtask

  task automatic t_sel();
    wr(0, 0, 16'h5000); // data base only
    access("R5 data base rewritten, limit kept", 16'h00FF, 16'h50FF, 0, 0);
    access("R5 data limit kept", 16'h0100, 16'h0000, 1, 0);
    access("R5 code untouched", 16'h8001, 16'h9001, 0, 1);
  endtask

  task automatic t_wrap();
    wr(0, 0, 16'hFFF0); wr(0, 1, 16'h8000);
    access("R3 wrap", 16'h0020, 16'h0010, 0, 0);
    access("R3 top offset", 16'h7FFF, 16'h7FEF, 0, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'b00; cfg_wdata = 16'h1000;
    req_valid = 1'b1; req_vaddr = 16'h0005;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R6 same-cycle uses old base", out_paddr, 16'hFFF5);
    access("R6 next uses new base", 16'h0005, 16'h1005, 0, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 16'h0003;   // A -> 0x1003
    @(negedge clk);
    req_vaddr = 16'h8004;                    // B -> 0x9004 waits
    chk("R8 stall valid", out_valid, 1);
    chk("R8 stall paddr", out_paddr, 16'h1003);
    chk("R8 stall refuses", req_ready, 0);
    @(negedge clk);
    chk("R8 held paddr", out_paddr, 16'h1003);
    chk("R8 held code", out_code, 0);
    chk("R8 still refuses", req_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second valid", out_valid, 1);
    chk("R8 second paddr", out_paddr, 16'h9004);
    chk("R8 second code", out_code, 1);
    @(negedge clk);
    chk("R8 drained", out_valid, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_bounds();
    t_sel();
    t_wrap();
    t_same_cycle();
    t_stall();
    summary();
  end
endmodule